// File: doc/BRIEF.md
# Alternating Phase-Shifter Rotation Controller

This block makes two bounded fine phase-shift units behave like one shifter that rotates without limit. Each unit holds an 8-bit setting from 0 to 255 and cannot wrap past either end. At any time one unit is active and its clock is chosen by the clock-select output. The other unit is the standby and waits at the end of its range where the rotation will next resume. Rotating upward, the standby waits at 0. Rotating downward, it waits at 255. When the active unit sits at its last setting and one more step in the same direction is requested, the controller flips the clock select to the standby unit. The two units then trade roles, and the new standby is walked back to the correct end, one step at a time.

Callers issue advance or retard requests through a valid/ready handshake. Each unit receives one step at a time, as an enable pulse with a direction bit. It answers with a one-cycle done pulse. The controller keeps its own count of both settings and updates it only on acknowledged steps. Accepted requests are spaced by a parameterised minimum number of clocks, 100 by default. Stepping continuously in one direction at that rate moves the output frequency by a small offset, roughly ±50 ppm. The clock mux and the phase-shift hardware are outside this block.

Top module: `phase_pingpong_ctrl`

## Requirements
- R1: After reset, unit A is active at setting 128, unit B is standby at 0, the rotation direction is up, `clkSel` is 0 (unit A) and `reqReady` is 1 while no request is presented.
- R2: A request is accepted in a cycle where `reqValid` and `reqReady` are both 1. If the active unit is not at its edge, the active unit's step enable pulses in that same cycle, with direction 1 (setting +1) for an advance (`reqUp`=1) or 0 (setting −1) for a retard. A step direction output is 0 whenever its enable is 0.
- R3: A unit receives no new step enable until it has returned `done` for its previous step, and `reqReady` stays 0 while any step is outstanding.
- R4: Two accepted requests are at least MIN_SPACING clock cycles apart.
- R5: An accepted advance while the active unit is at 255, or an accepted retard while it is at 0, issues no step. Instead `clkSel` toggles on the next clock and the units trade roles. `clkSel` changes at no other time.
- R6: Whenever the standby unit is not at its parking end (0 when rotating up, 255 when rotating down), it is stepped toward that end one acknowledged step at a time, and `reqReady` stays 0 until it arrives.
- R7: A request whose direction is opposite to the current rotation is not accepted in its first cycle. The rotation direction flips, the standby is re-parked at the opposite end, and only then is the request accepted.
- R8: A `done` pulse from a unit with no step outstanding is ignored and leaves the controller's settings and timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Phase step request present |
| reqUp | input | 1 | Request direction: 1 advance, 0 retard |
| reqReady | output | 1 | Controller can accept the request this cycle |
| stepEnA | output | 1 | One-cycle step enable to unit A |
| stepDirA | output | 1 | Step direction to unit A: 1 increases the setting |
| doneA | input | 1 | Unit A step acknowledge |
| stepEnB | output | 1 | One-cycle step enable to unit B |
| stepDirB | output | 1 | Step direction to unit B: 1 increases the setting |
| doneB | input | 1 | Unit B step acknowledge |
| clkSel | output | 1 | Output clock select: 0 unit A, 1 unit B |

## Verification
The bench drives the active unit to its upper edge and past it. A controller with an off-by-one edge test would step a unit to 256 or swap one request early, and the modelled unit and the per-cycle comparison catch that. It then reverses direction while the standby sits at 0. This forces a full re-park to 255 before any retard is accepted, so a design that skipped the re-park would later swap onto a unit at the wrong end. A second wrap downward checks the mirror case. Spurious acknowledges are injected while both units are idle, so a controller that counted them would drift and swap at the wrong request.

// File: rtl/phrot_pkg.sv
package phrot_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACT_WAIT,
    PH_PARK_WAIT
  } phState_t;

  typedef struct packed {
    logic bumpAct;    // acknowledged step of the active unit
    logic bumpStby;   // acknowledged parking step of the standby unit
    logic swapRoles;  // exchange active and standby
    logic flipDir;    // reverse the rotation direction
    logic armGap;     // restart the request spacing window
  } phStrobe_t;

endpackage

// File: rtl/phrot_datapath.sv
module phrot_datapath
  import phrot_pkg::*;
#(
  parameter int SET_W       = 8,
  parameter int MIN_SPACING = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  phStrobe_t stb,
  output logic      actSel,
  output logic      rotUp,
  output logic      actAtEdge,
  output logic      stbyParked,
  output logic      gapDone
);

  localparam int SET_MAX  = (1 << SET_W) - 1;
  localparam int SET_MID  = 1 << (SET_W - 1);
  localparam int GAP_W    = $clog2(MIN_SPACING + 1);
  localparam int GAP_LOAD = (MIN_SPACING > 0) ? MIN_SPACING - 1 : 0;

  logic [SET_W-1:0] actSet;
  logic [SET_W-1:0] stbySet;
  logic [SET_W-1:0] parkEnd;
  logic [GAP_W-1:0] gapCnt;

  // one shadow setting per unit
  for (genvar u = 0; u < 2; u++) begin : g_unit
    localparam logic [SET_W-1:0] RESET_VAL = (u == 0) ? SET_W'(SET_MID) : '0;
    logic             isAct;
    logic [SET_W-1:0] setting;

    assign isAct = (actSel == (u == 1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        setting <= RESET_VAL;
      end else if (stb.bumpAct && isAct) begin
        setting <= rotUp ? setting + 1'b1 : setting - 1'b1;
      end else if (stb.bumpStby && !isAct) begin
        // parking moves against the rotation
        setting <= rotUp ? setting - 1'b1 : setting + 1'b1;
      end
    end
  end

  assign actSet     = actSel ? g_unit[1].setting : g_unit[0].setting;
  assign stbySet    = actSel ? g_unit[0].setting : g_unit[1].setting;
  assign parkEnd    = rotUp ? '0 : SET_W'(SET_MAX);
  assign stbyParked = (stbySet == parkEnd);
  assign actAtEdge  = rotUp ? (actSet == SET_W'(SET_MAX)) : (actSet == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSel <= 1'b0;
      rotUp  <= 1'b1;
    end else begin
      if (stb.swapRoles) actSel <= ~actSel;
      if (stb.flipDir)   rotUp  <= ~rotUp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (stb.armGap) begin
      gapCnt <= GAP_W'(GAP_LOAD);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign gapDone = (gapCnt == '0);

endmodule

// File: rtl/phrot_control.sv
module phrot_control
  import phrot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqUp,
  input  logic       doneA,
  input  logic       doneB,
  input  logic       actSel,
  input  logic       rotUp,
  input  logic       actAtEdge,
  input  logic       stbyParked,
  input  logic       gapDone,
  output phStrobe_t  stb,
  output logic [1:0] stepEn,
  output logic [1:0] stepDir,
  output logic       reqReady
);

  phState_t state, stateNext;
  logic     doneAct, doneStby;
  logic     stbyIdx;

  assign doneAct  = actSel ? doneB : doneA;
  assign doneStby = actSel ? doneA : doneB;
  assign stbyIdx  = ~actSel;

  always_comb begin
    stb       = '0;
    stepEn    = '0;
    stepDir   = '0;
    reqReady  = 1'b0;
    stateNext = state;
    unique case (state)
      PH_IDLE: begin
        if (!stbyParked) begin
          stepEn[stbyIdx]  = 1'b1;
          stepDir[stbyIdx] = ~rotUp;
          stateNext        = PH_PARK_WAIT;
        end else if (reqValid && (reqUp != rotUp)) begin
          stb.flipDir = 1'b1;
        end else begin
          reqReady = gapDone;
          if (reqValid && gapDone) begin
            stb.armGap = 1'b1;
            if (actAtEdge) begin
              stb.swapRoles = 1'b1;
            end else begin
              stepEn[actSel]  = 1'b1;
              stepDir[actSel] = rotUp;
              stateNext       = PH_ACT_WAIT;
            end
          end
        end
      end
      PH_ACT_WAIT: begin
        if (doneAct) begin
          stb.bumpAct = 1'b1;
          stateNext   = PH_IDLE;
        end
      end
      PH_PARK_WAIT: begin
        if (doneStby) begin
          stb.bumpStby = 1'b1;
          stateNext    = PH_IDLE;
        end
      end
      default: stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/phase_pingpong_ctrl.sv
module phase_pingpong_ctrl
  import phrot_pkg::*;
#(
  parameter int SET_W       = 8,
  parameter int MIN_SPACING = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqUp,
  output logic reqReady,
  output logic stepEnA,
  output logic stepDirA,
  input  logic doneA,
  output logic stepEnB,
  output logic stepDirB,
  input  logic doneB,
  output logic clkSel
);

  phStrobe_t  stb;
  logic       actSel, rotUp, actAtEdge, stbyParked, gapDone;
  logic [1:0] stepEn, stepDir;

  phrot_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqUp      (reqUp),
    .doneA      (doneA),
    .doneB      (doneB),
    .actSel     (actSel),
    .rotUp      (rotUp),
    .actAtEdge  (actAtEdge),
    .stbyParked (stbyParked),
    .gapDone    (gapDone),
    .stb        (stb),
    .stepEn     (stepEn),
    .stepDir    (stepDir),
    .reqReady   (reqReady)
  );

  phrot_datapath #(
    .SET_W       (SET_W),
    .MIN_SPACING (MIN_SPACING)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .actSel     (actSel),
    .rotUp      (rotUp),
    .actAtEdge  (actAtEdge),
    .stbyParked (stbyParked),
    .gapDone    (gapDone)
  );

  assign stepEnA  = stepEn[0];
  assign stepDirA = stepDir[0];
  assign stepEnB  = stepEn[1];
  assign stepDirB = stepDir[1];
  assign clkSel   = actSel;

endmodule

// File: rtl/phase_pingpong_ctrl_chk.sv
module phase_pingpong_ctrl_chk #(
  parameter int MIN_SPACING = 100
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic stepEnA,
  input logic stepDirA,
  input logic doneA,
  input logic stepEnB,
  input logic stepDirB,
  input logic doneB,
  input logic clkSel
);

  logic busyA, busyB;
  int   sinceAccept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyA <= 1'b0;
      busyB <= 1'b0;
    end else begin
      if (stepEnA) busyA <= 1'b1; else if (doneA) busyA <= 1'b0;
      if (stepEnB) busyB <= 1'b1; else if (doneB) busyB <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sinceAccept <= MIN_SPACING;
    else if (reqValid && reqReady) sinceAccept <= 1;
    else if (sinceAccept < MIN_SPACING) sinceAccept <= sinceAccept + 1;
  end

  p_one_step_a_r3: assert property (@(posedge clk) disable iff (!rstN)
    stepEnA |-> !busyA);

  p_one_step_b_r3: assert property (@(posedge clk) disable iff (!rstN)
    stepEnB |-> !busyB);

  p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busyA && !busyB));

  p_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> (sinceAccept >= MIN_SPACING));

  p_sel_on_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel != $past(clkSel)) |-> $past(reqValid && reqReady));

  p_quiet_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEnA && !stepEnB) |-> (!stepDirA && !stepDirB));

endmodule

bind phase_pingpong_ctrl phase_pingpong_ctrl_chk #(.MIN_SPACING(MIN_SPACING)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .stepEnA  (stepEnA),
  .stepDirA (stepDirA),
  .doneA    (doneA),
  .stepEnB  (stepEnB),
  .stepDirB (stepDirB),
  .doneB    (doneB),
  .clkSel   (clkSel)
);

// File: tb/phase_pingpong_ctrl_test.sv
`timescale 1ns/1ps
module phase_pingpong_ctrl_test;

  localparam int SP  = 12;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqUp = 1'b0, doneA = 1'b0, doneB = 1'b0;
  logic reqReady, stepEnA, stepDirA, stepEnB, stepDirB, clkSel;

  always #4 clk = ~clk;

  phase_pingpong_ctrl #(.SET_W(8), .MIN_SPACING(SP)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqUp(reqUp), .reqReady(reqReady),
    .stepEnA(stepEnA), .stepDirA(stepDirA), .doneA(doneA),
    .stepEnB(stepEnB), .stepDirB(stepDirB), .doneB(doneB), .clkSel(clkSel)
  );

  int compared = 0, mismatched = 0, cycles = 0, accepted = 0, lastAccept = -1;
  int mSet[2] = '{128, 0};
  int mSel = 0, mUp = 1, mState = 0, mGap = 0;
  int cntA = 0, cntB = 0, physA = 128, physB = 0;
  logic wantValid = 1'b0, wantUp = 1'b0, injA = 1'b0, injB = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      int aIdx, sIdx, tgt, eRdy, nState;
      int eEn[2], eDir[2];
      logic dAct, dStby, flip, swap, acc;
      cycles++;
      if (cycles > 150000) begin
        chk("watchdog", 1, 0);
        summary();
      end
      doneA = (cntA == 1) || injA;
      doneB = (cntB == 1) || injB;
      injA = 1'b0; injB = 1'b0;
      if (cntA > 0) cntA--;
      if (cntB > 0) cntB--;
      reqValid = wantValid;
      reqUp = wantUp;
      #1;
      // reference model outputs for this cycle
      aIdx = mSel; sIdx = 1 - mSel;
      tgt = mUp ? 0 : 255;
      eEn = '{0, 0}; eDir = '{0, 0}; eRdy = 0; nState = mState;
      flip = 0; swap = 0; acc = 0;
      dAct = mSel ? doneB : doneA;
      dStby = mSel ? doneA : doneB;
      case (mState)
        0: begin
          if (mSet[sIdx] != tgt) begin
            eEn[sIdx] = 1; eDir[sIdx] = (tgt > mSet[sIdx]) ? 1 : 0; nState = 2;
          end else if (reqValid && (int'(reqUp) != mUp)) begin
            flip = 1;
          end else begin
            eRdy = (mGap == 0) ? 1 : 0;
            if (reqValid && eRdy == 1) begin
              acc = 1;
              if ((mUp == 1 && mSet[aIdx] == 255) || (mUp == 0 && mSet[aIdx] == 0)) swap = 1;
              else begin eEn[aIdx] = 1; eDir[aIdx] = mUp; nState = 1; end
            end
          end
        end
        1: if (dAct) begin mSet[aIdx] += mUp ? 1 : -1; nState = 0; end
        default: if (dStby) begin mSet[sIdx] += (tgt > mSet[sIdx]) ? 1 : -1; nState = 0; end
      endcase
      if (cycles == 1) begin
        chk("R1 clkSel after reset", int'(clkSel), 0);
        chk("R1 reqReady after reset", int'(reqReady), 1);
      end
      chk("R2 R6 stepEnA", int'(stepEnA), eEn[0]);
      chk("R2 R6 stepDirA", int'(stepDirA), eDir[0]);
      chk("R2 R6 stepEnB", int'(stepEnB), eEn[1]);
      chk("R2 R6 stepDirB", int'(stepDirB), eDir[1]);
      chk("R5 clkSel", int'(clkSel), mSel);
      chk("R3 R4 R7 reqReady", int'(reqReady), eRdy);
      if (reqValid && reqReady) begin
        if (lastAccept >= 0) chk("R4 accept spacing", int'(cycles - lastAccept >= SP), 1);
        lastAccept = cycles;
      end
      // modelled phase-shift hardware
      if (stepEnA) begin
        chk("R3 unit A busy", int'(cntA != 0), 0);
        cntA = LAT;
        physA += stepDirA ? 1 : -1;
        chk("R6 unit A range", int'(physA >= 0 && physA <= 255), 1);
      end
      if (stepEnB) begin
        chk("R3 unit B busy", int'(cntB != 0), 0);
        cntB = LAT;
        physB += stepDirB ? 1 : -1;
        chk("R6 unit B range", int'(physB >= 0 && physB <= 255), 1);
      end
      // model state advance
      if (acc) begin accepted++; mGap = SP - 1; end
      else if (mGap > 0) mGap--;
      if (flip) mUp = 1 - mUp;
      if (swap) mSel = 1 - mSel;
      mState = nState;
    end
  end

  task automatic doSteps(input int n, input logic up);
    int target;
    target = accepted + n;
    wantUp = up;
    wantValid = 1'b1;
    wait (accepted >= target);
    wantValid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2 rstN = 1'b1;
    settle(3);
    doSteps(5, 1'b1);
    settle(40);
    chk("R2 unit A after 5 advances", physA, 133);
    injA = 1'b1; injB = 1'b1;          // R8: stray acknowledges while idle
    settle(20);
    doSteps(123, 1'b1);                // 122 steps then the wrap
    settle(1500);
    chk("R5 select after upward wrap", int'(clkSel), 1);
    chk("R6 unit A parked low", physA, 0);
    chk("R8 unit B untouched", physB, 0);
    doSteps(10, 1'b1);
    settle(40);
    chk("R2 unit B after 10 advances", physB, 10);
    doSteps(1, 1'b0);                  // R7: reversal re-parks A at 255
    settle(40);
    chk("R7 unit A reparked high", physA, 255);
    chk("R7 unit B after retard", physB, 9);
    doSteps(10, 1'b0);                 // 9 steps then the downward wrap
    settle(1500);
    chk("R5 select after downward wrap", int'(clkSel), 0);
    chk("R6 unit B parked high", physB, 255);
    doSteps(3, 1'b0);
    settle(40);
    chk("R2 unit A after 3 retards", physA, 252);
    summary();
  end

endmodule